// File: doc/BRIEF.md
# Serial Register-File Slave with Display-Memory Streaming

This block is the control-port slave of a video overlay controller. A host drives a serial clock, an active-low select and a data line. The block shifts each frame into the system clock domain and decodes it. A normal frame is sixteen bits: a header byte first, then a data byte. Bit 7 of the header picks a read or a write, and bits 6:0 hold the register address. A write takes effect only when select returns high after exactly the expected number of bits. A read returns the chosen register, MSB first, on the serial output.

Two modes change the frame length. In streaming mode, each frame is a single data byte. That byte goes to the display-memory port at an internal pointer, and the pointer then advances. The byte 0xFF ends streaming mode and writes nothing. When the wide-character mode bit is set, reading the display-data address takes 24 bits and returns a full 16-bit memory word.

The serial pins are oversampled by the system clock. SCLK must run at no more than a quarter of the system clock rate. A 10 MHz serial clock therefore needs a system clock of at least 40 MHz.

Top module: `spi_regfile_slave`

## Requirements
- R1: After reset, the mode register, the start register, every user register and the pointer are zero. Streaming mode is off, dm_we is low and sdout_oe is low.
- R2: A 16-bit frame with header bit 7 = 0 writes its second byte to the register at header bits 6:0 once select returns high. The map is: 0x00 mode (bit 0 = wide characters), 0x01 start address, 0x02 streaming control, 0x08 to 0x08+NUSER-1 user registers.
- R3: A frame whose bit count differs from the expected length (8 in streaming mode, 24 for a wide display read, 16 otherwise) changes no register. This covers both a short frame and a long frame.
- R4: A frame with header bit 7 = 1 shifts the addressed register out on sdout, MSB first, during the 8 clocks after the header. sdout_oe is high only while select is low.
- R5: A read of an address with no register behind it returns 0x00.
- R6: Address 0x0F is a read-only status byte: bit 1 is streaming active and bit 0 is the wide-character mode. A write to it has no effect.
- R7: A write to 0x02 loads the pointer from the start register and sets streaming mode to the value of data bit 0. A read of 0x02 returns streaming active in bit 0.
- R8: In streaming mode, each complete 8-bit frame pulses dm_we for one cycle. The pulse carries the byte on dm_wdata and the pointer on dm_addr. The pointer then increments.
- R9: In streaming mode, the data byte 0xFF clears streaming mode and produces no dm_we pulse.
- R10: A read of address 0x03 returns display memory at the pointer. In wide mode the frame is 24 bits and returns all 16 bits of dm_rdata. Otherwise the frame is 16 bits and returns dm_rdata[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data in, taken on the SCLK rising edge |
| sdout | output | 1 | Serial data out, changes after the SCLK falling edge |
| sdout_oe | output | 1 | Output enable for the sdout pad driver |
| dm_addr | output | DM_AW | Display-memory address (the pointer) |
| dm_we | output | 1 | Display-memory write strobe |
| dm_wdata | output | 8 | Display-memory write byte |
| dm_rdata | input | 16 | Display-memory word at dm_addr |
| mode_wide | output | 1 | Wide-character mode bit |
| auto_active | output | 1 | Streaming mode is active |
| user_regs | output | 8*NUSER | User registers, register 0 in the low byte |

## Verification
Every serial pin passes through two synchronizer flops and one edge-detect flop before the frame logic acts on it. The frame logic registers its end strobe, and the register file registers its update. A write is therefore visible on the outputs about five system cycles after cs_n rises. The bench waits twelve cycles before it samples any output. A serial output bit changes at most four cycles after an SCLK falling edge, and the first read bit is loaded at most five cycles after the eighth rising edge. The bench holds each SCLK phase for six system cycles and samples sdout just before it raises SCLK. Because every change settles well inside that phase, each check falls in a cycle where the expected value is already stable.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int CNT_W = 5;
  localparam logic [CNT_W-1:0] LEN_STREAM = 5'd8;
  localparam logic [CNT_W-1:0] LEN_CMD    = 5'd16;
  localparam logic [CNT_W-1:0] LEN_WIDE   = 5'd24;
  localparam logic [CNT_W-1:0] CNT_MAX    = 5'd31;

  localparam logic [6:0] A_MODE   = 7'h00;
  localparam logic [6:0] A_START  = 7'h01;
  localparam logic [6:0] A_STREAM = 7'h02;
  localparam logic [6:0] A_DDATA  = 7'h03;
  localparam logic [6:0] A_USER   = 7'h08;
  localparam logic [6:0] A_STATUS = 7'h0F;

  localparam logic [7:0] STREAM_EXIT = 8'hFF;
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= RST_VAL;
    else     stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= RST_VAL;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_o <= RST_VAL;
    else     prev_o <= stage_q[STAGES-1];
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rf_frame.sv
module spi_rf_frame
  import spi_rf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sclk_rise,
  input  logic        sclk_fall,
  input  logic        cs_fall,
  input  logic        cs_rise,
  input  logic        cs_act,
  input  logic        sdin_s,
  input  logic        stream_i,
  input  logic        wide_i,
  input  logic [15:0] rd_word_i,
  output logic [7:0]  hdr_o,
  output logic [7:0]  data_o,
  output logic        end_stb_o,
  output logic        sdout,
  output logic        sdout_oe
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] exp_len;
  logic [7:0]       rx_q;
  logic [7:0]       hdr_q;
  logic             hdr_stb_q;
  logic [15:0]      tx_q;

  always_comb begin
    if (stream_i)                                   exp_len = LEN_STREAM;
    else if (hdr_q[7] && hdr_q[6:0] == A_DDATA && wide_i) exp_len = LEN_WIDE;
    else                                            exp_len = LEN_CMD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      rx_q      <= '0;
      hdr_q     <= '0;
      hdr_stb_q <= 1'b0;
      tx_q      <= '0;
      end_stb_o <= 1'b0;
      sdout_oe  <= 1'b0;
    end else begin
      hdr_stb_q <= 1'b0;
      end_stb_o <= 1'b0;
      sdout_oe  <= cs_act;
      if (cs_fall) begin
        cnt_q <= '0;
        tx_q  <= '0;
      end else if (cs_act && sclk_rise) begin
        rx_q <= {rx_q[6:0], sdin_s};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        if (cnt_q == 5'd7) begin
          hdr_q     <= {rx_q[6:0], sdin_s};
          hdr_stb_q <= 1'b1;
        end
      end
      if (hdr_stb_q && !stream_i && hdr_q[7]) begin
        tx_q <= rd_word_i;
      end else if (cs_act && sclk_fall && cnt_q > 5'd8) begin
        tx_q <= {tx_q[14:0], 1'b0};
      end
      if (cs_rise) end_stb_o <= (cnt_q == exp_len);
    end
  end

  assign hdr_o  = hdr_q;
  assign data_o = rx_q;
  assign sdout  = tx_q[15];

  // R4
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> !sdout_oe);
endmodule

// File: rtl/spi_rf_regs.sv
module spi_rf_regs
  import spi_rf_pkg::*;
#(
  parameter int NUSER = 4,
  parameter int DM_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               end_stb_i,
  input  logic [7:0]         hdr_i,
  input  logic [7:0]         data_i,
  output logic [15:0]        rd_word_o,
  output logic [DM_AW-1:0]   dm_addr,
  output logic               dm_we,
  output logic [7:0]         dm_wdata,
  input  logic [15:0]        dm_rdata,
  output logic               wide_o,
  output logic               stream_o,
  output logic [8*NUSER-1:0] user_flat
);
  localparam int UIW = (NUSER > 1) ? $clog2(NUSER) : 1;

  logic [7:0]       mode_q;
  logic [7:0]       start_q;
  logic             ai_q;
  logic [DM_AW-1:0] ptr_q;
  logic [7:0]       user_q [NUSER];
  logic             wr_cmd;
  logic [6:0]       rd_addr;
  logic [6:0]       uoff;

  assign wr_cmd  = end_stb_i && !ai_q && !hdr_i[7];
  assign rd_addr = hdr_i[6:0];
  assign uoff    = rd_addr - A_USER;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      start_q  <= '0;
      ai_q     <= 1'b0;
      ptr_q    <= '0;
      dm_addr  <= '0;
      dm_we    <= 1'b0;
      dm_wdata <= '0;
    end else begin
      dm_we   <= 1'b0;
      dm_addr <= ptr_q;
      if (end_stb_i && ai_q) begin
        if (data_i == STREAM_EXIT) begin
          ai_q <= 1'b0;
        end else begin
          dm_we    <= 1'b1;
          dm_wdata <= data_i;
          ptr_q    <= ptr_q + 1'b1;
        end
      end else if (wr_cmd) begin
        case (hdr_i[6:0])
          A_MODE:   mode_q  <= data_i;
          A_START:  start_q <= data_i;
          A_STREAM: begin
            ai_q  <= data_i[0];
            ptr_q <= DM_AW'(start_q);
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar u = 0; u < NUSER; u++) begin : g_user
    always_ff @(posedge clk) begin
      if (rst) user_q[u] <= '0;
      else if (wr_cmd && hdr_i[6:0] == 7'(A_USER + u)) user_q[u] <= data_i;
    end
    assign user_flat[8*u +: 8] = user_q[u];
  end

  always_comb begin
    rd_word_o = 16'h0000;
    if (rd_addr >= A_USER && rd_addr < 7'(A_USER + NUSER)) begin
      rd_word_o = {user_q[uoff[UIW-1:0]], 8'h00};
    end else begin
      case (rd_addr)
        A_MODE:   rd_word_o = {mode_q, 8'h00};
        A_START:  rd_word_o = {start_q, 8'h00};
        A_STREAM: rd_word_o = {7'b0, ai_q, 8'h00};
        A_DDATA:  rd_word_o = mode_q[0] ? dm_rdata : {dm_rdata[7:0], 8'h00};
        A_STATUS: rd_word_o = {6'b0, ai_q, mode_q[0], 8'h00};
        default:  rd_word_o = 16'h0000;
      endcase
    end
  end

  assign wide_o   = mode_q[0];
  assign stream_o = ai_q;

  // R8
  we_in_stream_chk: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> $past(ai_q));
  // R8
  we_single_chk: assert property (@(posedge clk) disable iff (rst)
    dm_we |=> !dm_we);
  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> ptr_q == dm_addr + 1'b1);
  // R9
  exit_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ai_q) |-> !dm_we);
  // R3
  user_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(user_flat) |-> $past(end_stb_i));
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave #(
  parameter int NUSER = 4,
  parameter int DM_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               sdin,
  output logic               sdout,
  output logic               sdout_oe,
  output logic [DM_AW-1:0]   dm_addr,
  output logic               dm_we,
  output logic [7:0]         dm_wdata,
  input  logic [15:0]        dm_rdata,
  output logic               mode_wide,
  output logic               auto_active,
  output logic [8*NUSER-1:0] user_regs
);
  logic [2:0]  pin_s;
  logic [2:0]  pin_p;
  logic        sync_unused;
  logic        sclk_rise, sclk_fall, cs_fall, cs_rise, cs_act;
  logic [7:0]  hdr, data;
  logic        end_stb;
  logic [15:0] rd_word;

  spi_rf_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .async_i({sdin, cs_n, sclk}),
    .sync_o(pin_s), .prev_o(pin_p)
  );

  assign sclk_rise   = pin_s[0] & ~pin_p[0];
  assign sclk_fall   = ~pin_s[0] & pin_p[0];
  assign cs_fall     = ~pin_s[1] & pin_p[1];
  assign cs_rise     = pin_s[1] & ~pin_p[1];
  assign cs_act      = ~pin_s[1];
  assign sync_unused = pin_p[2];

  spi_rf_frame u_frame (
    .clk(clk), .rst(rst),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_act(cs_act),
    .sdin_s(pin_s[2]), .stream_i(auto_active), .wide_i(mode_wide),
    .rd_word_i(rd_word), .hdr_o(hdr), .data_o(data), .end_stb_o(end_stb),
    .sdout(sdout), .sdout_oe(sdout_oe)
  );

  spi_rf_regs #(.NUSER(NUSER), .DM_AW(DM_AW)) u_regs (
    .clk(clk), .rst(rst), .end_stb_i(end_stb), .hdr_i(hdr), .data_i(data),
    .rd_word_o(rd_word), .dm_addr(dm_addr), .dm_we(dm_we),
    .dm_wdata(dm_wdata), .dm_rdata(dm_rdata), .wide_o(mode_wide),
    .stream_o(auto_active), .user_flat(user_regs)
  );
endmodule

// File: tb/spi_regfile_slave_test.sv
`timescale 1ns/1ps
module spi_regfile_slave_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdin = 1'b0;
  logic        sdout, sdout_oe, dm_we, mode_wide, auto_active;
  logic [7:0]  dm_addr, dm_wdata;
  logic [15:0] dm_rdata;
  logic [31:0] user_regs;
  int checks = 0, errors = 0, nwr = 0;
  bit done = 1'b0;
  logic [7:0] log_a [0:7];
  logic [7:0] log_d [0:7];

  always #4 clk = ~clk;

  function automatic logic [15:0] mem_word(logic [7:0] a);
    return {a ^ 8'hA5, ~a};
  endfunction
  assign dm_rdata = mem_word(dm_addr);

  spi_regfile_slave uut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdin(sdin),
    .sdout(sdout), .sdout_oe(sdout_oe), .dm_addr(dm_addr), .dm_we(dm_we),
    .dm_wdata(dm_wdata), .dm_rdata(dm_rdata), .mode_wide(mode_wide),
    .auto_active(auto_active), .user_regs(user_regs)
  );

  always @(posedge clk) begin
    if (!rst && dm_we) begin
      if (nwr < 8) begin
        log_a[nwr] <= dm_addr;
        log_d[nwr] <= dm_wdata;
      end
      nwr <= nwr + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic spi_xfer(input int nbits, input logic [23:0] mosi, output logic [23:0] miso);
    miso = '0;
    cs_n = 1'b0;
    #48;
    for (int i = nbits - 1; i >= 0; i--) begin
      sdin = mosi[i];
      #48;
      miso = {miso[22:0], sdout};
      sclk = 1'b1;
      #48;
      sclk = 1'b0;
    end
    #48;
    cs_n = 1'b1;
    sdin = 1'b0;
    repeat (12) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    logic [23:0] m;
    spi_xfer(16, {8'h00, 1'b0, a, d}, m);
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    logic [23:0] m;
    spi_xfer(16, {8'h00, 1'b1, a, 8'h00}, m);
    d = m[7:0];
  endtask

  task automatic t_reset;
    check("R1 user_regs", user_regs, 0);
    check("R1 mode_wide", mode_wide, 0);
    check("R1 auto_active", auto_active, 0);
    check("R1 dm_we", dm_we, 0);
    check("R1 sdout_oe", sdout_oe, 0);
    check("R1 dm_addr", dm_addr, 0);
  endtask

  task automatic t_write_read;
    logic [7:0] d;
    wr(7'h08, 8'h5A);
    check("R2 user0", user_regs[7:0], 8'h5A);
    wr(7'h0B, 8'hC3);
    check("R2 user3", user_regs[31:24], 8'hC3);
    rd(7'h08, d);
    check("R4 read user0", d, 8'h5A);
    rd(7'h0B, d);
    check("R4 read user3", d, 8'hC3);
    check("R4 oe idle", sdout_oe, 0);
  endtask

  task automatic t_unimpl;
    logic [7:0] d;
    rd(7'h20, d);
    check("R5 addr 0x20", d, 8'h00);
    rd(7'h7E, d);
    check("R5 addr 0x7E", d, 8'h00);
  endtask

  task automatic t_status;
    logic [7:0] d;
    wr(7'h00, 8'h01);
    check("R2 mode_wide", mode_wide, 1);
    wr(7'h0F, 8'hFF);
    rd(7'h0F, d);
    check("R6 status after write", d, 8'h01);
    check("R6 auto untouched", auto_active, 0);
    wr(7'h00, 8'h00);
  endtask

  task automatic t_abort;
    logic [23:0] m;
    spi_xfer(12, {12'h0, 4'h0, 8'h09}, m);
    check("R3 short frame", user_regs[15:8], 8'h00);
    spi_xfer(17, {7'h0, 1'b0, 7'h09, 8'h77, 1'b1}, m);
    check("R3 long frame", user_regs[15:8], 8'h00);
    check("R3 user0 kept", user_regs[7:0], 8'h5A);
  endtask

  task automatic t_stream;
    logic [23:0] m;
    logic [7:0] d;
    wr(7'h01, 8'h40);
    wr(7'h02, 8'h01);
    check("R7 auto_active", auto_active, 1);
    check("R7 pointer", dm_addr, 8'h40);
    spi_xfer(8, 24'h11, m);
    spi_xfer(8, 24'h22, m);
    spi_xfer(8, 24'h33, m);
    check("R8 write count", nwr, 3);
    check("R8 addr0", log_a[0], 8'h40);
    check("R8 data0", log_d[0], 8'h11);
    check("R8 addr2", log_a[2], 8'h42);
    check("R8 data2", log_d[2], 8'h33);
    check("R8 pointer after", dm_addr, 8'h43);
    spi_xfer(8, 24'hFF, m);
    check("R9 exit", auto_active, 0);
    check("R9 no write", nwr, 3);
    rd(7'h02, d);
    check("R7 readback", d, 8'h00);
  endtask

  task automatic t_dread;
    logic [23:0] m;
    logic [7:0] d;
    wr(7'h00, 8'h01);
    spi_xfer(24, {1'b1, 7'h03, 16'h0000}, m);
    check("R10 wide read", m[15:0], mem_word(8'h43));
    wr(7'h00, 8'h00);
    rd(7'h03, d);
    check("R10 narrow read", d, mem_word(8'h43) & 16'h00FF);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_write_read();
    t_unimpl();
    t_status();
    t_abort();
    t_stream();
    t_dread();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule